// File: doc/BRIEF.md
# Serial Configuration Chain Shifter

This block drives a long serial configuration chain through a small register interface. Software writes a control word that holds up to 32 data bits, a bit count, a shift request, an update request and a one-hot group select. The block then moves that many bits into the selected chains, one bit per period of a divided clock. The bits that fall out of the chain end are collected back into the same data word, and the shift request clears by itself when the last bit has moved. An update request copies the chain contents of each selected group into that group's parallel holding latches, which model the settings that the lanes see.

Each group's chain holds four lanes of 268 bits, 1072 bits in total. The chain and the 32-bit data register together form a loop: the data register's low bit feeds the chain, and the bit leaving the chain enters the data register's high end. A second register sets the clock divider exponent, a per-group bypass mask and a selector that chooses which group's holding latches are shown on the observation port. Software polls the live request flags to learn when an operation has ended.

Top module: `cfgc_chain_ctl`

## Requirements
- R1: After reset both readback words are zero and the observation port is zero.
- R2: Each bit of a shift takes 2^(div+2) core cycles, with div in config bits [3:0], so the shift flag (control bit 40) reads high for exactly N*2^(div+2) cycles.
- R3: Control bits [36:32] hold N-1, and exactly N bits move (N from 1 to 32).
- R4: Data bit 0 enters the chain first; after N bits the data word reads {the N bits that left the chain, the unsent data bits shifted down by N}, the first bit out landing at position 32-N.
- R5: The shift flag and the update flag (control bit 41) clear by themselves when their work is done.
- R6: An update copies the chain of every selected group (control bits 48 and up, one bit per group) into its holding latches one divided period after it starts; groups not selected keep their latches.
- R7: A group whose bypass bit (config bits 16 and up) is set neither shifts nor updates; the returned bit comes from the lowest-numbered selected group that is not bypassed, and is zero when none is.
- R8: The observation port shows the holding latches of the group chosen by config bits starting at 8.
- R9: A write to either register while the shift or update flag is set is ignored.
- R10: When a control word sets both requests, the shift runs first and the update follows, so the update flag reads high for N*2^(div+2)+2^(div+2) cycles.
- R11: A bit shifted into a chain returns in the data word after exactly 1072 further bit shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 config, 1 control |
| wr_data | input | 64 | Write data |
| rd_addr | input | 1 | Readback source: 0 config, 1 control |
| rd_data | output | 64 | Registered readback word, one cycle behind |
| hold_obs | output | 1072 | Registered holding latches of the observed group |

## Verification
A wrong bit counter or divider phase shows at once as a flag that stays high too long or too short, measured cycle by cycle on the readback port, and as a data word with its returned bits misplaced. A fault in the chain or the return path stays hidden until the affected bits come back around the loop or an update exposes the chain on the observation port, which can take up to 1072 bit shifts; the bench therefore mixes short random shifts with full-loop runs and frequent updates.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
  localparam int CSR_W   = 64;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 5;
  // control word fields
  localparam int F_CNT   = 32;
  localparam int F_SHIFT = 40;
  localparam int F_UPD   = 41;
  localparam int F_SEL   = 48;
  // config word fields
  localparam int F_DIV   = 0;
  localparam int F_MUX   = 8;
  localparam int F_BYP   = 16;

  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CTL = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_UPD   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cfgc_clkdiv.sv
module cfgc_clkdiv #(
  parameter int DIV_W   = 4,
  parameter int PHASE_W = (1 << DIV_W) + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] limit;
  logic [DIV_W:0]     sh_amt;

  assign sh_amt = {1'b0, div} + (DIV_W+1)'(2);
  assign limit  = (PHASE_W'(1) << sh_amt) - PHASE_W'(1);
  assign tick   = run && (phase == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else if (phase == limit) phase <= '0;
    else phase <= phase + PHASE_W'(1);
  end

  // period is at least four cycles, so ticks never touch
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/cfgc_group.sv
module cfgc_group #(
  parameter int CHAIN_LEN = 1072
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 din,
  input  logic                 upd_en,
  output logic                 dout,
  output logic [CHAIN_LEN-1:0] hold
);
  logic [CHAIN_LEN-1:0] chain;

  assign dout = chain[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      hold  <= '0;
    end else begin
      if (shift_en) chain <= {din, chain[CHAIN_LEN-1:1]};
      if (upd_en)   hold  <= chain;
    end
  end

  // shift and update never land in the same cycle
  assert_single_op_R10: assert property (@(posedge clk) disable iff (rst)
    !(shift_en && upd_en));
endmodule

// File: rtl/cfgc_seq.sv
module cfgc_seq
  import cfgc_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int DIV_W      = 4,
  parameter int SEL_W      = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [CSR_W-1:0]      wr_data,
  input  logic                  tick,
  input  logic                  ret_bit,
  output logic                  run,
  output logic                  shift_pulse,
  output logic                  upd_pulse,
  output logic                  shift_bit,
  output logic [NUM_GROUPS-1:0] sel,
  output logic [NUM_GROUPS-1:0] bypass,
  output logic [SEL_W-1:0]      mux_sel,
  output logic [DIV_W-1:0]      div,
  output logic [CSR_W-1:0]      ctl_word,
  output logic [CSR_W-1:0]      cfg_word
);
  seq_state_t          state;
  logic                shift_flag, upd_flag, busy, accept;
  logic [DATA_W-1:0]   data_q;
  logic [CNT_W-1:0]    cnt_q, bits_left;
  logic                unused_wr;

  assign unused_wr   = ^wr_data;
  assign busy        = shift_flag | upd_flag;
  assign accept      = wr_en && !busy;
  assign run         = busy;
  assign shift_pulse = (state == ST_SHIFT) && tick;
  assign upd_pulse   = (state == ST_UPD) && tick;
  assign shift_bit   = data_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shift_flag <= 1'b0;
      upd_flag   <= 1'b0;
      data_q     <= '0;
      cnt_q      <= '0;
      bits_left  <= '0;
      sel        <= '0;
      bypass     <= '0;
      mux_sel    <= '0;
      div        <= '0;
    end else if (accept && wr_addr == ADDR_CTL) begin
      data_q     <= wr_data[DATA_W-1:0];
      cnt_q      <= wr_data[F_CNT +: CNT_W];
      bits_left  <= wr_data[F_CNT +: CNT_W];
      sel        <= wr_data[F_SEL +: NUM_GROUPS];
      shift_flag <= wr_data[F_SHIFT];
      upd_flag   <= wr_data[F_UPD];
      if (wr_data[F_SHIFT])    state <= ST_SHIFT;
      else if (wr_data[F_UPD]) state <= ST_UPD;
      else                     state <= ST_IDLE;
    end else if (accept) begin
      div     <= wr_data[F_DIV +: DIV_W];
      mux_sel <= wr_data[F_MUX +: SEL_W];
      bypass  <= wr_data[F_BYP +: NUM_GROUPS];
    end else begin
      case (state)
        ST_SHIFT: if (tick) begin
          data_q <= {ret_bit, data_q[DATA_W-1:1]};
          if (bits_left == '0) begin
            shift_flag <= 1'b0;
            state      <= upd_flag ? ST_UPD : ST_IDLE;
          end else begin
            bits_left <= bits_left - CNT_W'(1);
          end
        end
        ST_UPD: if (tick) begin
          upd_flag <= 1'b0;
          state    <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl_word                     = '0;
    ctl_word[DATA_W-1:0]         = data_q;
    ctl_word[F_CNT +: CNT_W]     = cnt_q;
    ctl_word[F_SHIFT]            = shift_flag;
    ctl_word[F_UPD]              = upd_flag;
    ctl_word[F_SEL +: NUM_GROUPS] = sel;
    cfg_word                     = '0;
    cfg_word[F_DIV +: DIV_W]     = div;
    cfg_word[F_MUX +: SEL_W]     = mux_sel;
    cfg_word[F_BYP +: NUM_GROUPS] = bypass;
  end

  // a shift only ends on a divided-clock tick
  assert_shift_ends_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_flag) |-> $past(tick));
  // the last bit drops the shift flag
  assert_last_bit_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_pulse && bits_left == '0) |=> !shift_flag);
  // writes during busy leave the registers alone
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> ($stable(sel) && $stable(div) && $stable(bypass) && $stable(cnt_q)));
  // with both requests, the update waits for the shift
  assert_update_after_shift_R10: assert property (@(posedge clk) disable iff (rst)
    (shift_flag && upd_flag) |-> !upd_pulse);
endmodule

// File: rtl/cfgc_chain_ctl.sv
module cfgc_chain_ctl
  import cfgc_pkg::*;
#(
  parameter int NUM_GROUPS      = 2,
  parameter int LANES_PER_GROUP = 4,
  parameter int BITS_PER_LANE   = 268,
  parameter int DIV_W           = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr_en,
  input  logic                                     wr_addr,
  input  logic [63:0]                              wr_data,
  input  logic                                     rd_addr,
  output logic [63:0]                              rd_data,
  output logic [LANES_PER_GROUP*BITS_PER_LANE-1:0] hold_obs
);
  localparam int CHAIN_LEN = LANES_PER_GROUP * BITS_PER_LANE;
  localparam int SEL_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic                  tick, run, shift_pulse, upd_pulse, shift_bit, ret_bit;
  logic [NUM_GROUPS-1:0] sel, bypass, grp_en, chain_out;
  logic [SEL_W-1:0]      mux_sel;
  logic [DIV_W-1:0]      div;
  logic [CSR_W-1:0]      ctl_word, cfg_word;
  logic [CHAIN_LEN-1:0]  hold_w [NUM_GROUPS];

  assign grp_en = sel & ~bypass;

  cfgc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .div(div), .tick(tick)
  );

  cfgc_seq #(.NUM_GROUPS(NUM_GROUPS), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .ret_bit(ret_bit), .run(run), .shift_pulse(shift_pulse),
    .upd_pulse(upd_pulse), .shift_bit(shift_bit), .sel(sel), .bypass(bypass),
    .mux_sel(mux_sel), .div(div), .ctl_word(ctl_word), .cfg_word(cfg_word)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    cfgc_group #(.CHAIN_LEN(CHAIN_LEN)) u_grp (
      .clk(clk), .rst(rst),
      .shift_en(shift_pulse && grp_en[g]),
      .din(shift_bit),
      .upd_en(upd_pulse && grp_en[g]),
      .dout(chain_out[g]),
      .hold(hold_w[g])
    );

    // a bypassed group keeps its latches
    assert_bypass_hold_R7: assert property (@(posedge clk) disable iff (rst)
      bypass[g] |=> $stable(hold_w[g]));
  end

  // lowest-numbered enabled group feeds the return path
  always_comb begin
    ret_bit = 1'b0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--)
      if (grp_en[g]) ret_bit = chain_out[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      hold_obs <= '0;
    end else begin
      rd_data <= (rd_addr == ADDR_CTL) ? ctl_word : cfg_word;
      if (int'(mux_sel) < NUM_GROUPS) hold_obs <= hold_w[mux_sel];
      else                            hold_obs <= '0;
    end
  end
endmodule

// File: tb/tb_cfgc_chain_ctl.sv
`timescale 1ns/1ps
module tb_cfgc_chain_ctl;
  localparam int CL = 1072;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [63:0]   wr_data = '0;
  logic          rd_addr = 1'b1;
  logic [63:0]   rd_data;
  logic [CL-1:0] hold_obs;

  int checks = 0;
  int errors = 0;

  logic [CL-1:0] cm [2];
  logic [CL-1:0] hm [2];
  logic [1:0]    byp_m = '0;
  logic [3:0]    div_m = '0;
  logic          mux_m = 1'b0;

  always #10 clk = ~clk;

  cfgc_chain_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hold_obs(hold_obs)
  );

  task automatic chk(string tag, logic [CL-1:0] got, logic [CL-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_shift(int n, logic [31:0] d, logic [1:0] sel);
    logic [1:0] en;
    logic       outb;
    en = sel & ~byp_m;
    for (int i = 0; i < n; i++) begin
      outb = 1'b0;
      if (en[1]) outb = cm[1][0];
      if (en[0]) outb = cm[0][0];
      for (int g = 0; g < 2; g++)
        if (en[g]) cm[g] = {d[0], cm[g][CL-1:1]};
      d = {outb, d[31:1]};
    end
    return d;
  endfunction

  task automatic csr_wr(logic a, logic [63:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int sc, output int uc);
    sc = 0; uc = 0;
    for (int guard = 0; guard < 150000; guard++) begin
      @(negedge clk);
      if (!rd_data[40] && !rd_data[41]) break;
      if (rd_data[40]) sc++;
      if (rd_data[41]) uc++;
    end
  endtask

  task automatic set_cfg(logic [3:0] dv, logic mx, logic [1:0] bp);
    logic [63:0] w;
    w = '0; w[3:0] = dv; w[8] = mx; w[17:16] = bp;
    rd_addr = 1'b1;
    csr_wr(1'b0, w);
    div_m = dv; mux_m = mx; byp_m = bp;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_ctl(string tag, int n, logic [31:0] d, logic [1:0] sel, logic sh, logic up);
    logic [63:0] w;
    logic [31:0] exp_d;
    logic [1:0]  en;
    int sc, uc, per;
    per = 1 << (int'(div_m) + 2);
    w = '0; w[31:0] = d; w[36:32] = 5'(n - 1); w[40] = sh; w[41] = up; w[49:48] = sel;
    exp_d = sh ? model_shift(n, d, sel) : d;
    rd_addr = 1'b1;
    csr_wr(1'b1, w);
    wait_idle(sc, uc);
    chk({tag, " R2 shift cycles"}, CL'(sc), CL'(sh ? n * per : 0));
    chk({tag, " R10 update cycles"}, CL'(uc), CL'(up ? ((sh ? n * per : 0) + per) : 0));
    chk({tag, " R5 flags clear"}, CL'(rd_data[41:40]), '0);
    chk({tag, " R3 R4 data word"}, CL'(rd_data[31:0]), CL'(exp_d));
    if (up) begin
      en = sel & ~byp_m;
      for (int g = 0; g < 2; g++) if (en[g]) hm[g] = cm[g];
      chk({tag, " R6 holding latches"}, hold_obs, hm[mux_m]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sc, uc;
    logic [63:0] w;
    void'($urandom(32'h00C0FFEE));
    cm[0] = '0; cm[1] = '0; hm[0] = '0; hm[1] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 control readback", CL'(rd_data), '0);
    rd_addr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 config readback", CL'(rd_data), '0);
    chk("R1 observation", hold_obs, '0);

    // R11: a 32-bit pattern comes back after 1072 more bit shifts
    set_cfg(4'd0, 1'b0, 2'b00);
    do_ctl("R11 load", 32, 32'hC3A5_0F1E, 2'b01, 1'b1, 1'b0);
    for (int k = 0; k < 32; k++) do_ctl("R11 fill", 32, 32'h0, 2'b01, 1'b1, 1'b0);
    do_ctl("R11 fill", 16, 32'h0, 2'b01, 1'b1, 1'b0);
    do_ctl("R11 return", 32, 32'h0, 2'b01, 1'b1, 1'b0);
    chk("R11 loop return", CL'(rd_data[31:0]), CL'(32'hC3A5_0F1E));

    // R3 boundary counts, R2 with other dividers
    do_ctl("R3 one bit", 1, 32'hFFFF_FFFF, 2'b11, 1'b1, 1'b0);
    set_cfg(4'd1, 1'b0, 2'b00);
    do_ctl("R3 full word", 32, 32'h1234_5678, 2'b10, 1'b1, 1'b1);
    set_cfg(4'd2, 1'b1, 2'b00);
    do_ctl("R10 both requests", 7, 32'h0000_005A, 2'b11, 1'b1, 1'b1);
    do_ctl("R6 update only", 1, 32'h0, 2'b01, 1'b0, 1'b1);

    // R9: writes while busy are ignored
    set_cfg(4'd2, 1'b0, 2'b00);
    w = '0; w[31:0] = 32'hA5A5_5A5A; w[36:32] = 5'd31; w[40] = 1'b1; w[48] = 1'b1;
    void'(model_shift(32, 32'hA5A5_5A5A, 2'b01));
    csr_wr(1'b1, w);
    repeat (10) @(negedge clk);
    csr_wr(1'b1, 64'h0002_0223_0000_0001);
    csr_wr(1'b0, 64'h0000_0000_0003_0105);
    wait_idle(sc, uc);
    chk("R9 no update from ignored write", CL'(uc), '0);
    chk("R9 select kept", CL'(rd_data[49:48]), CL'(2'b01));
    rd_addr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 config kept", CL'(rd_data[23:0]), CL'(24'h000002));
    rd_addr = 1'b1;

    // R7: bypass freezes a group and steers the return path
    set_cfg(4'd0, 1'b1, 2'b10);
    do_ctl("R7 bypass one", 32, 32'h0F0F_F0F0, 2'b11, 1'b1, 1'b1);
    do_ctl("R7 none eligible", 20, 32'hDEAD_BEEF, 2'b10, 1'b1, 1'b1);
    chk("R7 zeros returned", CL'(rd_data[31:20]), '0);
    set_cfg(4'd0, 1'b1, 2'b00);
    do_ctl("R7 release", 32, 32'h8000_0001, 2'b11, 1'b1, 1'b1);

    // R8: observation port follows the group selector
    do_ctl("R8 diverge", 32, 32'h7777_1111, 2'b01, 1'b1, 1'b1);
    set_cfg(4'd0, 1'b0, 2'b00);
    chk("R8 group 0 view", hold_obs, hm[0]);
    set_cfg(4'd0, 1'b1, 2'b00);
    chk("R8 group 1 view", hold_obs, hm[1]);

    // random mix
    for (int k = 0; k < 120; k++) begin
      int n, r;
      logic [31:0] d;
      logic [1:0]  s;
      if (k % 30 == 0)
        set_cfg(4'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00);
      n = $urandom_range(1, 32);
      d = $urandom;
      s = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 7);
      do_ctl("random", n, d, s, r != 0, r < 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule